// File: doc/BRIEF.md
# Watchdog Kick Pattern Generator

This block sits in an application configuration image and drives the refresh ("kick") line and the companion reset line of a read-only remote-update controller. Three slide switches choose a test pattern, so a tester can either keep the configuration watchdog alive or deliberately starve it and watch the device fall back to its recovery image. The block also drives a 1 Hz heartbeat and shows each switch on an active-low indicator.

The switches pass through a two-flop synchroniser. Switches 1 and 0 pick a kick mode. TOGGLE (00 or 11) refreshes forever. ONCE (01) gives one pulse and then stays low. STUCK (10) rises once and then stays high. Switch 2 is a separate override that keeps the reset line low without touching the kick line. A pattern sequencer produces the kick. Its states are ST_START (output low), ST_PULSE (output high), ST_REST_LO and ST_REST_HI, and each of ST_START and ST_PULSE lasts PHASE_CYCLES clocks. It has five transitions:
- ST_START moves to ST_PULSE when its phase ends.
- ST_PULSE moves back to ST_START when its phase ends in TOGGLE mode.
- ST_PULSE moves to ST_REST_LO when its phase ends in ONCE mode.
- ST_PULSE moves to ST_REST_HI when its phase ends in STUCK mode.
- Any state returns to ST_START, with its timer cleared, when the synchronised mode changes.

The two rest states hold until the mode changes.

Top module: `wdog_kick_gen`

## Requirements
- R1: While `rst` is high, `kick_o`, `app_rst_o` and `beat_o` are 0. The synchroniser clears, so `ind_n_o` reads 0.
- R2: In TOGGLE mode (`sw_i[1:0]` = 00 or 11), `kick_o` alternates forever. Every complete high run and every complete low run lasts exactly PHASE_CYCLES clocks, and no run is longer.
- R3: On entering ONCE mode (`sw_i[1:0]` = 01), `kick_o` is low for PHASE_CYCLES clocks, then high for exactly PHASE_CYCLES clocks, then low until the mode changes.
- R4: On entering STUCK mode (`sw_i[1:0]` = 10), `kick_o` is low for PHASE_CYCLES clocks, then rises once and stays high until the mode changes.
- R5: `app_rst_o` equals `kick_o` while the synchronised `sw_i[2]` is 0, and is 0 while it is 1.
- R6: `beat_o` toggles every CLK_HZ/2 clocks, which gives one flash per second at CLK_HZ.
- R7: `ind_n_o[i]` shows synchronised `sw_i[i]`, so an indicator is driven low (lit) when its switch reads 0.
- R8: Switches reach the logic two clocks after they change. A change of mode restarts the sequencer at ST_START with `kick_o` low. A change of `sw_i[2]` alone, or between 00 and 11, does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_i | input | 3 | Switches: [1:0] select the mode, [2] holds the reset line low |
| kick_o | output | 1 | Watchdog refresh line |
| app_rst_o | output | 1 | Companion reset line |
| beat_o | output | 1 | 1 Hz heartbeat |
| ind_n_o | output | 3 | Active-low switch indicators |

## Verification
The bench measures exact high and low run lengths, which catches an off-by-one phase counter that would make the kick period one clock long or short. It re-selects ONCE and STUCK while already in that mode and changes only switch 2. A design that restarts on any switch change would emit a second pulse there. It also checks that a STUCK-to-ONCE switch and the reverse restart from low, because a sequencer that kept its old rest state would leave the kick stuck, or let the watchdog survive when it should expire. Finally, it times the synchroniser delay on one indicator and checks the override, where reset must stay low while the kick keeps moving.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        ST_START   = 2'd0,
        ST_PULSE   = 2'd1,
        ST_REST_LO = 2'd2,
        ST_REST_HI = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'd0,
        MODE_ONCE   = 2'd1,
        MODE_STUCK  = 2'd2
    } kick_mode_t;

    function automatic kick_mode_t decode_mode(input logic [1:0] sel);
        kick_mode_t m;
        unique case (sel)
            2'b01:   m = MODE_ONCE;
            2'b10:   m = MODE_STUCK;
            default: m = MODE_TOGGLE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/wdk_seq.sv
module wdk_seq
    import wdk_pkg::*;
#(
    parameter int PHASE_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  kick_mode_t mode_i,
    output logic       kick_o
);
    localparam int TW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(PHASE_CYCLES - 1);

    seq_state_t state_q, state_d;
    kick_mode_t mode_q;
    logic [TW-1:0] timer_q;
    logic mode_chg;
    logic phase_done;
    logic timed;

    assign mode_chg   = (mode_i != mode_q);
    assign timed      = (state_q == ST_START) || (state_q == ST_PULSE);
    assign phase_done = timed && (timer_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: if (phase_done) state_d = ST_PULSE;
            ST_PULSE: begin
                if (phase_done) begin
                    unique case (mode_q)
                        MODE_ONCE:  state_d = ST_REST_LO;
                        MODE_STUCK: state_d = ST_REST_HI;
                        default:    state_d = ST_START;
                    endcase
                end
            end
            ST_REST_LO: state_d = ST_REST_LO;
            ST_REST_HI: state_d = ST_REST_HI;
        endcase
        if (mode_chg) state_d = ST_START;
    end

    // state register, timer and mode memory
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_START;
            mode_q  <= MODE_TOGGLE;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_i;
            if (mode_chg || phase_done || !timed) timer_q <= '0;
            else                                  timer_q <= timer_q + 1'b1;
        end
    end

    // registered output, aligned with the state register
    always_ff @(posedge clk) begin
        if (rst) kick_o <= 1'b0;
        else     kick_o <= (state_d == ST_PULSE) || (state_d == ST_REST_HI);
    end

    // R2
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        timer_q <= LAST);
    // R3
    rise_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(kick_o) |-> ($past(state_q) == ST_START));
    // R4
    stuck_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REST_HI && $past(state_q) == ST_REST_HI) |-> $stable(kick_o));
    // R8
    restart_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode_chg) |-> !kick_o);
endmodule

// File: rtl/wdk_beat.sv
module wdk_beat #(
    parameter int CLK_HZ = 6250000
) (
    input  logic clk,
    input  logic rst,
    output logic beat_o
);
    localparam int HALF = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            beat_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            beat_o <= ~beat_o;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R6
    beat_period_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_o != $past(beat_o)) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/wdog_kick_gen.sv
module wdog_kick_gen
    import wdk_pkg::*;
#(
    parameter int PHASE_CYCLES = 100000,
    parameter int CLK_HZ       = 6250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sw_i,
    output logic       kick_o,
    output logic       app_rst_o,
    output logic       beat_o,
    output logic [2:0] ind_n_o
);
    logic [2:0] sw_s;
    kick_mode_t mode;

    wdk_sync #(.WIDTH(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sw_i),
        .q_o (sw_s)
    );

    assign mode = decode_mode(sw_s[1:0]);

    wdk_seq #(.PHASE_CYCLES(PHASE_CYCLES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .kick_o (kick_o)
    );

    wdk_beat #(.CLK_HZ(CLK_HZ)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .beat_o (beat_o)
    );

    assign app_rst_o = kick_o & ~sw_s[2];
    assign ind_n_o   = sw_s;

    // R5
    rst_needs_kick_chk: assert property (@(posedge clk) disable iff (rst)
        app_rst_o |-> kick_o);
endmodule

// File: tb/wdog_kick_gen_bench.sv
module wdog_kick_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P     = 6;
    localparam int HZ    = 20;
    localparam int HALF  = HZ / 2;
    localparam int WIN   = 6 * P;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] sw = 3'b000;
    logic kick, app_rst, beat;
    logic [2:0] ind_n;

    int checks = 0;
    int failures = 0;
    int cur_mode = 0;   // 0 toggle, 1 once, 2 stuck
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_kick_gen #(.PHASE_CYCLES(P), .CLK_HZ(HZ)) u_wdog_kick_gen (
        .clk(clk), .rst(rst), .sw_i(sw), .kick_o(kick),
        .app_rst_o(app_rst), .beat_o(beat), .ind_n_o(ind_n)
    );

    function automatic int mode_of(input logic [1:0] s);
        if (s == 2'b01) return 1;
        if (s == 2'b10) return 2;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R6 heartbeat run lengths, checked throughout
    int bprev = 0, brun = 0;
    bit bseen = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (int'(beat) != bprev) begin
                if (bseen) check(brun == HALF, "R6", "beat run", brun, HALF);
                bseen = 1'b1;
                brun = 1;
                bprev = int'(beat);
            end else begin
                brun++;
                if (brun == HALF + 1) check(1'b0, "R6", "beat run too long", brun, HALF);
            end
        end
    end

    task automatic run_window(input logic [2:0] s);
        int nm, rises, falls, run, maxrun, badrun, bad_exp, rmis, prev;
        bit seen, restarted;
        rises = 0; falls = 0; run = 0; maxrun = 0; badrun = -1; rmis = 0;
        seen = 1'b0;
        @(negedge clk);
        sw = s;
        nm = mode_of(s[1:0]);
        restarted = (nm != cur_mode);
        cur_mode = nm;
        repeat (SETTLE) @(negedge clk);
        prev = int'(kick);
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (app_rst !== (s[2] ? 1'b0 : kick)) rmis++;
            if (int'(kick) != prev) begin
                if (seen && run != P) badrun = run;
                if (kick) rises++; else falls++;
                seen = 1'b1;
                run = 1;
                prev = int'(kick);
            end else run++;
            if (run > maxrun) maxrun = run;
        end
        check(rmis == 0, "R5", "reset line mismatches", rmis, 0);
        check(ind_n == s, "R7", "indicators", int'(ind_n), int'(s));
        bad_exp = -1;
        if (nm == 0) begin
            check(rises >= 2 && falls >= 2, "R2", "toggle edges", rises + falls, 4);
            check(badrun == bad_exp, "R2", "toggle run length", badrun, P);
            check(maxrun <= P, "R2", "longest run", maxrun, P);
        end else if (nm == 1) begin
            if (restarted) begin
                check(rises == 1 && falls == 1, "R3", "once edges", rises * 10 + falls, 11);
                check(badrun == bad_exp, "R3", "pulse width", badrun, P);
            end else begin
                check(rises + falls == 0, "R8", "no restart once", rises + falls, 0);
            end
            check(kick == 1'b0, "R3", "once final level", int'(kick), 0);
        end else begin
            if (restarted)
                check(rises == 1 && falls == 0, "R4", "stuck edges", rises * 10 + falls, 10);
            else
                check(rises + falls == 0, "R8", "no restart stuck", rises + falls, 0);
            check(kick == 1'b1, "R4", "stuck final level", int'(kick), 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(kick == 1'b0, "R1", "kick in reset", int'(kick), 0);
        check(app_rst == 1'b0, "R1", "reset line in reset", int'(app_rst), 0);
        check(beat == 1'b0, "R1", "beat in reset", int'(beat), 0);
        check(ind_n == 3'b000, "R1", "indicators in reset", int'(ind_n), 0);
        rst = 1'b0;
        // R8 synchroniser delay on switch 2 (no mode change)
        @(negedge clk); sw = 3'b100;
        @(negedge clk);
        check(ind_n[2] == 1'b0, "R8", "ind after 1 clk", int'(ind_n[2]), 0);
        @(negedge clk);
        check(ind_n[2] == 1'b1, "R8", "ind after 2 clk", int'(ind_n[2]), 1);
        // directed corners
        run_window(3'b000);
        run_window(3'b001);
        run_window(3'b101);   // same mode, override only: no restart
        run_window(3'b010);
        run_window(3'b110);   // same mode: no restart
        run_window(3'b001);   // stuck -> once
        run_window(3'b010);   // once -> stuck
        run_window(3'b011);
        run_window(3'b000);   // 11 -> 00 keeps toggling
        run_window(3'b100);
        // constrained random
        for (int n = 0; n < 24; n++) run_window(3'($urandom_range(0, 7)));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule